// File: doc/BRIEF.md
# I2C Register-Pointer Target Interface

This block is the serial front end of a small configuration register file. It listens on a two-wire bus, answers its own 7-bit device address, and turns each bus transfer into byte accesses on a simple parallel register port. The first byte of every write transfer loads an internal register pointer. Each later byte is written to the location the pointer selects, and the pointer then advances. Read transfers return bytes starting at the stored pointer and advance it the same way.

The upper five bits of the device address are fixed at binary 10011. Two strap inputs supply the lowest two bits, so four copies can share one bus. Write addresses are therefore 0x98, 0x9A, 0x9C and 0x9E, and each read address is one higher. Both bus lines are brought into the system clock domain through a two-stage synchronizer and then edge-detected. The data line is driven only through an open-drain enable. An active-low shutdown input keeps the interface silent and clears its pointer for as long as it is held low.

Top module: `i2c_regptr_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal {10011, strap_i[1], strap_i[0]}. For any other address it leaves SDA released and produces no write strobe until the next START or STOP.
- R2: For a matching address byte and for every byte it receives in a write transfer, the target pulls SDA low (sda_oe=1) throughout the high phase of the 9th SCL clock.
- R3: In a write transfer the first byte after the address loads the pointer. A STOP straight after that byte produces no write strobe, but the pointer keeps the value for later reads.
- R4: Each further byte of a write transfer is written to wr_addr = pointer, and the pointer then increments. It wraps from 0xFF to 0x00.
- R5: Every write strobe lasts exactly one clock cycle. It rises after the 8th data bit has been sampled and before the ACK clock, so sda_oe is 0 while wr_stb is 1.
- R6: A read transfer returns the byte at rd_addr = pointer, most significant bit first. The pointer increments after each byte, so consecutive bytes come from consecutive addresses.
- R7: Once the controller answers a read byte with NACK (SDA high on the 9th clock), the target keeps SDA released on every later clock until the next START.
- R8: A repeated START ends the current transfer and begins a new address phase. The pointer written before it is kept.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a byte discards that byte with no write strobe.
- R10: While shdn_n is low the target never drives SDA, never acknowledges and never strobes. The pointer is cleared to 0x00.
- R11: After reset sda_oe=0, wr_stb=0 and rd_addr=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shdn_n | input | 1 | Active-low shutdown; interface inactive while low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_i | input | 2 | Low two bits of the device address |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 8 | Register data for the write |
| rd_addr | output | 8 | Current pointer, used as the read address |
| rd_data | input | 8 | Register contents at rd_addr |

## Verification
A table of four write-then-read patterns runs the main path. The patterns differ in strap setting, start pointer and data (all ones, all zeros, alternating bits), and two of them cross the 0xFF-to-0x00 pointer wrap. Together they separate an address decoder that ignores the straps, a pointer that fails to wrap or increment, and a byte-order error in the read shifter. Directed frames then cover a transfer that carries only the pointer, a mismatched address, extra clocks after a NACK, a STOP in the middle of a byte, and a frame sent during shutdown. Each of these tells apart stored state from state that was wrongly updated or wrongly cleared.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RX    = 3'd1,
        ST_ACK   = 3'd2,
        ST_TX    = 3'd3,
        ST_TXACK = 3'd4
    } tgt_state_e;

    typedef enum logic [1:0] {
        BK_ADDR = 2'd0,
        BK_PTR  = 2'd1,
        BK_DATA = 2'd2
    } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign lvl_o  = pipe_q[STAGES-1];
    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int              PTR_W    = 8,
    parameter int              PREFIX_W = 5,
    parameter logic [PREFIX_W-1:0] PREFIX = 5'b10011,
    parameter int              STRAP_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn_n,
    input  logic               scl_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic               sda_rise,
    input  logic               sda_fall,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_oe,
    output logic               wr_stb,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [PTR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]  rd_data
);
    localparam int DEVA_W = PREFIX_W + STRAP_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        tgt_state_e          st;
        byte_kind_e          kind;
        logic                rw;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   txreg;
        logic [PTR_W-1:0]    ptr;
        logic                drv;
        logic                pend;
        logic                oe;
        logic                stb;
        logic [PTR_W-1:0]    waddr;
        logic [BYTE_W-1:0]   wdata;
    } regs_t;

    regs_t q, d;

    logic [BYTE_W-1:0] rx_byte;
    logic [DEVA_W-1:0] own_addr;
    logic              start_ev, stop_ev;

    assign rx_byte  = {q.shreg[BYTE_W-2:0], sda_lvl};
    assign own_addr = {PREFIX, strap};
    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (!shdn_n) begin
            d = '0;
        end else if (start_ev) begin
            d.st   = ST_RX;
            d.kind = BK_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.drv  = 1'b0;
            d.pend = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: if (scl_rise) begin
                    d.shreg = rx_byte;
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.drv = 1'b0;
                        unique case (q.kind)
                            BK_ADDR: begin
                                d.rw = rx_byte[0];
                                if (rx_byte[BYTE_W-1:1] != own_addr) d.st = ST_IDLE;
                            end
                            BK_PTR: d.ptr = PTR_W'(rx_byte);
                            default: begin
                                d.stb   = 1'b1;
                                d.waddr = q.ptr;
                                d.wdata = rx_byte;
                                d.ptr   = q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (!q.drv) begin
                        d.drv = 1'b1;
                        d.oe  = 1'b1;
                    end else begin
                        d.drv = 1'b0;
                        d.oe  = 1'b0;
                        if (q.kind == BK_ADDR && q.rw) begin
                            d.txreg = rd_data;
                            d.ptr   = q.ptr + 1'b1;
                            d.st    = ST_TX;
                            d.cnt   = '0;
                            d.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.kind = (q.kind == BK_ADDR) ? BK_PTR : BK_DATA;
                            d.cnt  = '0;
                        end
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (q.cnt == LAST_BIT) begin
                        d.st   = ST_TXACK;
                        d.oe   = 1'b0;
                        d.cnt  = '0;
                        d.pend = 1'b0;
                    end else begin
                        d.txreg = {q.txreg[BYTE_W-2:0], 1'b0};
                        d.cnt   = q.cnt + 1'b1;
                        d.oe    = ~q.txreg[BYTE_W-2];
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) d.st   = ST_IDLE;
                        else         d.pend = 1'b1;
                    end else if (scl_fall && q.pend) begin
                        d.txreg = rd_data;
                        d.ptr   = q.ptr + 1'b1;
                        d.st    = ST_TX;
                        d.cnt   = '0;
                        d.pend  = 1'b0;
                        d.oe    = ~rd_data[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign wr_stb  = q.stb;
    assign wr_addr = q.waddr;
    assign wr_data = q.wdata;
    assign rd_addr = q.ptr;
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = 8,
    parameter int STRAP_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               wr_stb,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic [PTR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]  rd_data
);
    localparam int N_LINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    i2c_tgt_fsm #(.PTR_W(PTR_W), .STRAP_W(STRAP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shdn_n   (shdn_n),
        .scl_lvl  (lvl[1]),
        .scl_rise (rise[1]),
        .scl_fall (fall[1]),
        .sda_lvl  (lvl[0]),
        .sda_rise (rise[0]),
        .sda_fall (fall[0]),
        .strap    (strap_i),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic clk,
    input logic rst_n,
    input logic shdn_n,
    input logic scl_i,
    input logic sda_oe,
    input logic wr_stb
);
    // R10
    shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!sda_oe && !wr_stb));

    // R5
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5
    stb_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !sda_oe);

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && $past(shdn_n) && !$stable(sda_oe)) |-> !scl_i);
endmodule

bind i2c_regptr_target i2c_tgt_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .shdn_n (shdn_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .wr_stb (wr_stb)
);

// File: tb/sim_i2c_regptr_target.sv
module sim_i2c_regptr_target;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    localparam int Q = 4;

    logic       rst_n = 1'b0, shdn_n = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_oe, wr_stb;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0] dev_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] stb_addr [64];
    logic [7:0] stb_data [64];
    int stb_n = 0, total = 0, bad = 0;

    assign rd_data = dev_mem[rd_addr];

    i2c_regptr_target u0 (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            dev_mem[wr_addr] <= wr_data;
            if (stb_n < 64) begin
                stb_addr[stb_n] <= wr_addr;
                stb_data[stb_n] <= wr_data;
            end
            stb_n <= stb_n + 1;
            check("R5 no drive during strobe", {31'd0, sda_oe}, 32'd0);
        end
    end

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic bit_out(input logic b);
        wait_q(1); sda_m = b; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic r);
        wait_q(1); sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        r = sda_line; wait_q(1);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack);
    endtask

    task automatic rd_byte(output logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) bit_in(b[i]);
        bit_out(nack);
    endtask

    // {strap, pointer, data0, data1}
    localparam logic [25:0] VEC [4] = '{
        {2'b00, 8'h01, 8'hA5, 8'h3C},
        {2'b01, 8'h10, 8'hFF, 8'h00},
        {2'b10, 8'hFE, 8'h12, 8'h34},
        {2'b11, 8'hFF, 8'h77, 8'h88}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R9 act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         n0;
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (6) @(negedge clk);
        check("R11 reset sda_oe", {31'd0, sda_oe}, 32'd0);
        check("R11 reset wr_stb", {31'd0, wr_stb}, 32'd0);
        check("R11 reset rd_addr", {24'd0, rd_addr}, 32'd0);
        rst_n = 1'b1;
        wait_q(2);

        // main table: write two bytes, then read them back through a repeated START
        for (int v = 0; v < 4; v++) begin
            logic [1:0] s;
            logic [7:0] p, d0, d1;
            {s, p, d0, d1} = VEC[v];
            strap = s;
            wait_q(1);
            n0 = stb_n;
            bus_start();
            wr_byte({5'b10011, s, 1'b0}, ack); check("R1 address ack", {31'd0, ack}, 32'd0);
            wr_byte(p, ack);  check("R2 pointer ack", {31'd0, ack}, 32'd0);
            wr_byte(d0, ack); check("R2 data0 ack", {31'd0, ack}, 32'd0);
            wr_byte(d1, ack); check("R2 data1 ack", {31'd0, ack}, 32'd0);
            bus_stop();
            exp_mem[p] = d0;
            exp_mem[8'(p + 8'd1)] = d1;
            check("R4 strobe count", stb_n - n0, 32'd2);
            check("R4 first addr", {24'd0, stb_addr[n0]}, {24'd0, p});
            check("R4 second addr wraps", {24'd0, stb_addr[n0 + 1]}, {24'd0, 8'(p + 8'd1)});
            check("R4 first data", {24'd0, stb_data[n0]}, {24'd0, d0});
            check("R4 second data", {24'd0, stb_data[n0 + 1]}, {24'd0, d1});

            bus_start();
            wr_byte({5'b10011, s, 1'b0}, ack);
            wr_byte(p, ack);
            bus_start();
            wr_byte({5'b10011, s, 1'b1}, ack); check("R8 read address after Sr", {31'd0, ack}, 32'd0);
            rd_byte(rb, 1'b0); check("R6 read byte0", {24'd0, rb}, {24'd0, exp_mem[p]});
            rd_byte(rb, 1'b1); check("R6 read byte1", {24'd0, rb}, {24'd0, exp_mem[8'(p + 8'd1)]});
            bus_stop();
        end

        // R3: a pointer-only write stores the pointer, no strobe
        strap = 2'b00; wait_q(1);
        n0 = stb_n;
        bus_start();
        wr_byte(8'h98, ack);
        wr_byte(8'h40, ack); check("R3 pointer ack", {31'd0, ack}, 32'd0);
        bus_stop();
        check("R3 no strobe", stb_n - n0, 32'd0);
        bus_start();
        wr_byte(8'h99, ack);
        rd_byte(rb, 1'b1); check("R3 read at stored pointer", {24'd0, rb}, {24'd0, exp_mem[8'h40]});

        // R7: extra clocks after NACK see a released line
        begin
            logic any_low = 1'b0;
            for (int i = 0; i < 9; i++) begin
                bit_in(ack);
                if (!ack) any_low = 1'b1;
            end
            check("R7 released after NACK", {31'd0, any_low}, 32'd0);
        end
        bus_stop();

        // R1: mismatched address (strap 00, address for strap 01)
        n0 = stb_n;
        bus_start();
        wr_byte(8'h9A, ack); check("R1 mismatch nack", {31'd0, ack}, 32'd1);
        wr_byte(8'h55, ack); check("R1 mismatch byte nack", {31'd0, ack}, 32'd1);
        bus_stop();
        check("R1 mismatch no strobe", stb_n - n0, 32'd0);

        // R9: STOP in the middle of a data byte
        n0 = stb_n;
        bus_start();
        wr_byte(8'h98, ack);
        wr_byte(8'h20, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        check("R9 mid-byte stop no strobe", stb_n - n0, 32'd0);
        bus_start();
        wr_byte(8'h99, ack);
        rd_byte(rb, 1'b1); check("R9 pointer kept", {24'd0, rb}, {24'd0, exp_mem[8'h20]});
        bus_stop();

        // R10: shutdown ignores frames and clears the pointer
        shdn_n = 1'b0; wait_q(2);
        n0 = stb_n;
        bus_start();
        wr_byte(8'h98, ack); check("R10 no ack in shutdown", {31'd0, ack}, 32'd1);
        wr_byte(8'h30, ack);
        wr_byte(8'hC3, ack); check("R10 no data ack in shutdown", {31'd0, ack}, 32'd1);
        bus_stop();
        check("R10 no strobe in shutdown", stb_n - n0, 32'd0);
        check("R10 pointer cleared", {24'd0, rd_addr}, 32'd0);
        shdn_n = 1'b1; wait_q(2);
        bus_start();
        wr_byte(8'h99, ack); check("R10 ack after release", {31'd0, ack}, 32'd0);
        rd_byte(rb, 1'b1); check("R10 read from pointer 0", {24'd0, rb}, {24'd0, exp_mem[8'h00]});
        bus_stop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule